// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block plays the device end of a serial keyboard link. The host writes command bytes, and the block answers some of them by loading fixed reply sequences into a small byte queue. Key press and release events from the keyboard matrix logic are turned into scan-code bytes and loaded into the same queue. The host empties the queue one byte at a time, using a pop strobe. The head byte and a data-available flag are always visible at the outputs.

The queue accepts one byte per cycle, so a multi-byte reply is sequenced over several cycles. A key event wins any cycle it shares with the reply sequencer, and the reply then resumes one cycle later with no byte lost. Lock keys (caps and num by default) go through a two-bit press/release filter. The filter turns the two press/release pairs of a latched key into one press report and one release report.

Top module: `kbd_responder`

## Requirements
- R1: After reset the queue is empty, `data_avail` is 0 and `head_byte` is 0x00.
- R2: Command 0x01 empties the queue on its cycle, then loads 0xFF, 0x04 and 0x7F over the next three cycles, in that order.
- R3: Commands 0x07 and 0x0F each empty the queue, then load 0xFE followed by 0x21.
- R4: Command 0x0E arms a one-shot flag. The next command byte, whatever its value, is discarded and clears the flag. Command bytes after it are decoded normally.
- R5: Any command value other than 0x01, 0x07, 0x0E and 0x0F leaves the queue unchanged.
- R6: A key event loads {key_up, key_code}: bit 7 is 1 for a release and 0 for a press, and bits 6:0 carry the 7-bit code.
- R7: Each lock key has a two-bit state that starts at 0. A press toggles bit 0 and is dropped if the state becomes 2. A release toggles bit 1 and is dropped if the state becomes 3. Keys that are not lock keys always pass.
- R8: The queue holds DEPTH (default 16) bytes in arrival order. A load into a full queue is dropped.
- R9: When the queue is empty, `head_byte` reads 0x00, and a pop has no effect.
- R10: A key event and a reply byte that fall in the same cycle both reach the queue. The key byte goes first, and the reply resumes in the next cycle.
- R11: `data_avail` is 1 exactly when the queue holds at least one byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte strobe, one cycle per byte |
| cmd_byte | input | 8 | Command byte from the host |
| key_valid | input | 1 | Key event strobe |
| key_code | input | 7 | Key code |
| key_up | input | 1 | 1 for release, 0 for press |
| pop | input | 1 | Remove the head byte |
| head_byte | output | 8 | Oldest queued byte, 0x00 when empty |
| data_avail | output | 1 | Queue not empty |

## Verification
The assertions assume that strobes are single-cycle events sampled on rising edges, and that a pop is only taken as removing a byte when the queue is not empty. They also assume that a lock-key event always changes that key's filter state. The stimulus drives every strobe for exactly one cycle, away from the clock edge. Between table steps it leaves enough idle cycles for any reply sequence to finish. Only one test overlaps a key event with a running reply, to exercise the arbitration on purpose.

// File: rtl/kbr_pkg.sv
package kbr_pkg;
   localparam logic [7:0] CMD_RESET   = 8'h01;
   localparam logic [7:0] CMD_LAYOUT0 = 8'h07;
   localparam logic [7:0] CMD_LEDSET  = 8'h0E;
   localparam logic [7:0] CMD_LAYOUT1 = 8'h0F;

   typedef enum logic {REP_RESET = 1'b0, REP_LAYOUT = 1'b1} reply_e;

   function automatic logic [7:0] reply_byte(reply_e kind, logic [1:0] idx);
      logic [7:0] b;
      b = 8'h00;
      if (kind == REP_RESET) begin
         case (idx)
            2'd0: b = 8'hFF;
            2'd1: b = 8'h04;
            default: b = 8'h7F;
         endcase
      end else begin
         b = (idx == 2'd0) ? 8'hFE : 8'h21;
      end
      return b;
   endfunction

   function automatic logic [1:0] reply_last(reply_e kind);
      return (kind == REP_RESET) ? 2'd2 : 2'd1;
   endfunction
endpackage

// File: rtl/kbr_fifo.sv
module kbr_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] rd_data,
   output logic         not_empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("kbr_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] count;
   logic          accept, take;

   assign accept    = push && (flush || count != FULL_CNT);
   assign take      = pop && (count != '0) && !flush;
   assign not_empty = (count != '0);
   assign rd_data   = not_empty ? mem[rptr] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (flush) begin
         rptr  <= '0;
         wptr  <= accept ? AW'(1) : '0;
         count <= accept ? CW'(1) : '0;
      end else begin
         if (accept) wptr <= wptr + 1'b1;
         if (take)   rptr <= rptr + 1'b1;
         count <= count + CW'(accept) - CW'(take);
      end
   end

   always_ff @(posedge clk) begin
      if (accept) mem[flush ? '0 : wptr] <= push_data;
   end

   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);
   a_r8_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (count == FULL_CNT && !pop && !flush) |=> count == FULL_CNT);
   a_r9_empty_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && pop && !push && !flush) |=> count == '0);
endmodule

// File: rtl/kbr_cmd_seq.sv
module kbr_cmd_seq
   import kbr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_byte,
   input  logic       stall,
   output logic       flush,
   output logic       emit,
   output logic [7:0] emit_byte
);
   logic       led_armed;
   logic       active;
   reply_e     kind;
   logic [1:0] idx;
   logic       live, go_reset, go_layout;

   assign live      = cmd_valid && !led_armed;
   assign go_reset  = live && cmd_byte == CMD_RESET;
   assign go_layout = live && (cmd_byte == CMD_LAYOUT0 || cmd_byte == CMD_LAYOUT1);
   assign flush     = go_reset || go_layout;
   assign emit      = active && !stall && !flush;
   assign emit_byte = reply_byte(kind, idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         led_armed <= 1'b0;
         active    <= 1'b0;
         kind      <= REP_RESET;
         idx       <= '0;
      end else begin
         if (cmd_valid) led_armed <= !led_armed && cmd_byte == CMD_LEDSET;
         if (flush) begin
            active <= 1'b1;
            kind   <= go_reset ? REP_RESET : REP_LAYOUT;
            idx    <= '0;
         end else if (emit) begin
            if (idx == reply_last(kind)) active <= 1'b0;
            else                         idx    <= idx + 1'b1;
         end
      end
   end

   a_r4_led_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && led_armed) |=> !led_armed);
   a_r2_seq_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !led_armed && cmd_byte == CMD_RESET) |=> (active && idx == 2'd0));
   a_r4_armed_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && led_armed) |-> !flush);
endmodule

// File: rtl/kbr_lock_filter.sv
module kbr_lock_filter #(
   parameter int          CODE_W    = 7,
   parameter logic [6:0]  LOCK_CODE = 7'h77
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_valid,
   input  logic [CODE_W-1:0] key_code,
   input  logic              key_up,
   output logic              drop
);
   logic [1:0] st, st_nx;
   logic       hit;

   assign hit   = key_valid && key_code == CODE_W'(LOCK_CODE);
   assign st_nx = key_up ? (st ^ 2'b10) : (st ^ 2'b01);
   assign drop  = hit && (key_up ? st_nx == 2'd3 : st_nx == 2'd2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st <= 2'd0;
      else if (hit) st <= st_nx;
   end

   a_r7_state_steps: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> st != $past(st));
endmodule

// File: rtl/kbd_responder.sv
module kbd_responder
   import kbr_pkg::*;
#(
   parameter int          DEPTH      = 16,
   parameter int          CODE_W     = 7,
   parameter int          NUM_LOCKS  = 2,
   parameter logic [13:0] LOCK_CODES = {7'h62, 7'h77}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_byte,
   input  logic              key_valid,
   input  logic [CODE_W-1:0] key_code,
   input  logic              key_up,
   input  logic              pop,
   output logic [7:0]        head_byte,
   output logic              data_avail
);
   localparam int BYTE_W = CODE_W + 1;

   if (BYTE_W != 8) begin : g_bad_width
      $error("kbd_responder: CODE_W must be 7 so a key byte fills 8 bits");
   end
   if (NUM_LOCKS < 1 || NUM_LOCKS * CODE_W > 14) begin : g_bad_locks
      $error("kbd_responder: NUM_LOCKS out of range for LOCK_CODES");
   end

   logic [NUM_LOCKS-1:0] drops;
   logic                 key_push;
   logic                 seq_flush, seq_emit;
   logic [7:0]           seq_byte;

   for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
      kbr_lock_filter #(
         .CODE_W    (CODE_W),
         .LOCK_CODE (LOCK_CODES[i*7 +: 7])
      ) u_filt (
         .clk       (clk),
         .rst_n     (rst_n),
         .key_valid (key_valid),
         .key_code  (key_code),
         .key_up    (key_up),
         .drop      (drops[i])
      );
   end

   assign key_push = key_valid && ~|drops;

   kbr_cmd_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_byte  (cmd_byte),
      .stall     (key_push),
      .flush     (seq_flush),
      .emit      (seq_emit),
      .emit_byte (seq_byte)
   );

   kbr_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (seq_flush),
      .push      (key_push || seq_emit),
      .push_data (key_push ? {key_up, key_code} : seq_byte),
      .pop       (pop),
      .rd_data   (head_byte),
      .not_empty (data_avail)
   );

   a_r10_one_source: assert property (@(posedge clk) disable iff (!rst_n)
      !(key_push && seq_emit));
   a_r11_avail_head: assert property (@(posedge clk) disable iff (!rst_n)
      !data_avail |-> head_byte == 8'h00);
endmodule

// File: tb/kbd_responder_test.sv
module kbd_responder_test;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 31;
   // entry: op[22:21] (0 cmd, 1 key, 2 pop), arg[20:13], avail[12], head[11:4], req[3:0]
   localparam logic [22:0] VEC [NVEC] = '{
      {2'd0, 8'h01, 1'b1, 8'hFF, 4'd2},  // R2 reset reply
      {2'd2, 8'h00, 1'b1, 8'h04, 4'd2},  // R2
      {2'd2, 8'h00, 1'b1, 8'h7F, 4'd2},  // R2
      {2'd2, 8'h00, 1'b0, 8'h00, 4'd11}, // R11 empties
      {2'd2, 8'h00, 1'b0, 8'h00, 4'd9},  // R9 pop on empty
      {2'd0, 8'h07, 1'b1, 8'hFE, 4'd3},  // R3
      {2'd0, 8'h0F, 1'b1, 8'hFE, 4'd3},  // R3 flush then reply
      {2'd2, 8'h00, 1'b1, 8'h21, 4'd3},  // R3
      {2'd2, 8'h00, 1'b0, 8'h00, 4'd3},  // R3 only two bytes
      {2'd0, 8'h0E, 1'b0, 8'h00, 4'd4},  // R4 arm
      {2'd0, 8'h01, 1'b0, 8'h00, 4'd4},  // R4 swallowed
      {2'd0, 8'h01, 1'b1, 8'hFF, 4'd4},  // R4 flag cleared
      {2'd0, 8'h55, 1'b1, 8'hFF, 4'd5},  // R5 ignored
      {2'd2, 8'h00, 1'b1, 8'h04, 4'd5},  // R5 queue untouched
      {2'd2, 8'h00, 1'b1, 8'h7F, 4'd5},  // R5
      {2'd2, 8'h00, 1'b0, 8'h00, 4'd5},  // R5
      {2'd1, 8'h1C, 1'b1, 8'h1C, 4'd6},  // R6 press
      {2'd1, 8'h9C, 1'b1, 8'h1C, 4'd6},  // R6 release queued behind
      {2'd2, 8'h00, 1'b1, 8'h9C, 4'd6},  // R6 bit 7 set
      {2'd2, 8'h00, 1'b0, 8'h00, 4'd6},  // R6
      {2'd1, 8'h77, 1'b1, 8'h77, 4'd7},  // R7 first press passes
      {2'd2, 8'h00, 1'b0, 8'h00, 4'd7},  // R7
      {2'd1, 8'hF7, 1'b0, 8'h00, 4'd7},  // R7 first release dropped
      {2'd1, 8'h77, 1'b0, 8'h00, 4'd7},  // R7 second press dropped
      {2'd1, 8'hF7, 1'b1, 8'hF7, 4'd7},  // R7 second release passes
      {2'd2, 8'h00, 1'b0, 8'h00, 4'd7},  // R7
      {2'd1, 8'h62, 1'b1, 8'h62, 4'd7},  // R7 second lock key
      {2'd2, 8'h00, 1'b0, 8'h00, 4'd7},  // R7
      {2'd0, 8'h0E, 1'b0, 8'h00, 4'd4},  // R4 arm
      {2'd0, 8'h07, 1'b0, 8'h00, 4'd4},  // R4 swallowed
      {2'd0, 8'h0F, 1'b1, 8'hFE, 4'd4}   // R4 decoded again
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_byte = 8'h00;
   logic       key_valid = 1'b0;
   logic [6:0] key_code = 7'h00;
   logic       key_up = 1'b0;
   logic       pop = 1'b0;
   logic [7:0] head_byte;
   logic       data_avail;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   kbd_responder uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .key_valid(key_valid), .key_code(key_code), .key_up(key_up), .pop(pop),
      .head_byte(head_byte), .data_avail(data_avail)
   );

   task automatic check(string req, logic exp_av, logic [7:0] exp_hd);
      checks++;
      if (data_avail !== exp_av || head_byte !== exp_hd) begin
         errors++;
         $display("FAIL %s: avail=%0b head=%02h expected avail=%0b head=%02h",
                  req, data_avail, head_byte, exp_av, exp_hd);
      end
   endtask

   task automatic drive(logic [1:0] op, logic [7:0] arg);
      @(negedge clk);
      case (op)
         2'd0: begin cmd_valid = 1'b1; cmd_byte = arg; end
         2'd1: begin key_valid = 1'b1; key_up = arg[7]; key_code = arg[6:0]; end
         default: pop = 1'b1;
      endcase
      @(negedge clk);
      cmd_valid = 1'b0; key_valid = 1'b0; pop = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset state", 1'b0, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 1'b0, 8'h00);

      for (int v = 0; v < NVEC; v++) begin
         drive(VEC[v][22:21], VEC[v][20:13]);
         repeat (3) @(negedge clk);
         checks++;
         if (data_avail !== VEC[v][12] || head_byte !== VEC[v][11:4]) begin
            errors++;
            $display("FAIL R%0d row %0d: avail=%0b head=%02h expected avail=%0b head=%02h",
                     VEC[v][3:0], v, data_avail, head_byte, VEC[v][12], VEC[v][11:4]);
         end
      end
      drive(2'd2, 8'h00);
      drive(2'd2, 8'h00);
      check("R9 drained", 1'b0, 8'h00);

      // R8: seventeen back-to-back presses, the last one dropped
      for (int k = 0; k < 17; k++) begin
         @(negedge clk);
         key_valid = 1'b1; key_up = 1'b0; key_code = 7'(8'h10 + k);
      end
      @(negedge clk);
      key_valid = 1'b0;
      for (int k = 0; k < 16; k++) begin
         check("R8 order", 1'b1, 8'(8'h10 + k));
         drive(2'd2, 8'h00);
      end
      check("R8 overflow dropped", 1'b0, 8'h00);

      // R10: key event lands while reply is being emitted
      @(negedge clk);
      cmd_valid = 1'b1; cmd_byte = 8'h01;
      @(negedge clk);
      cmd_valid = 1'b0;
      @(negedge clk);
      key_valid = 1'b1; key_up = 1'b0; key_code = 7'h33;
      @(negedge clk);
      key_valid = 1'b0;
      repeat (4) @(negedge clk);
      check("R10 first", 1'b1, 8'hFF);
      drive(2'd2, 8'h00);
      check("R10 key between", 1'b1, 8'h33);
      drive(2'd2, 8'h00);
      check("R10 resumed", 1'b1, 8'h04);
      drive(2'd2, 8'h00);
      check("R10 last", 1'b1, 8'h7F);
      drive(2'd2, 8'h00);
      check("R10 end", 1'b0, 8'h00);

      // R1: reset in the middle of use
      drive(2'd0, 8'h07);
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid reset", 1'b0, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 stays empty", 1'b0, 8'h00);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule